// File: doc/BRIEF.md
# Hibernate Wakeup Filter and Reset Sequencer

This block controls whether the rest of a chip has power, using a slow reference tick of about 32 kHz that arrives as a one-cycle enable on the system clock. When software writes a 1 to bit 0 of the hibernate register, the block drops its power-enable output. It then watches an active-low wakeup pin. The pin counts as a real wakeup only if it stays asserted on a programmed number of consecutive tick samples. Shorter pulses are treated as noise and ignored.

After a valid wakeup, power-enable returns high and a system reset output is driven low for a programmed number of ticks. The reset output is then released and the block is back in its running state. Software sets the two durations through a small register write port:

| Register | Offset | Significant bits |
|---|---|---|
| Minimum wakeup assert time | 0x24 | 15:5 |
| Reset width | 0x28 | 11:5 |

The bits below the significant field are dropped. Out of reset the two durations are 1952 ticks and 3264 ticks. At 32 kHz these are about 60 ms of wakeup assertion and 100 ms of reset.

Top module: `hib_wake_seq`

## Requirements
- R1: Out of reset, powerEn is 1 and sysRstN is 1 (running state).
- R2: While running, a write to offset 0x20 with wrData bit 0 = 1 drives powerEn to 0 on the cycle after the write edge.
- R3: The following writes change nothing at the outputs:
  - a write to offset 0x20 with bit 0 = 0;
  - a write with bit 0 = 1 to any other offset;
  - any write to 0x20 while hibernating or holding reset.
- R4: wakePinN is active-low and passes through a two-flop synchronizer. While hibernating, the synchronized pin is sampled only on cycles with tickEn = 1. With F = wrData & 0xFFE0 as last written to offset 0x24, a wakeup happens on the (F+1)-th consecutive asserted sample: F asserted samples alone do not wake.
- R5: A deasserted sample during hibernation restarts the count of consecutive asserted samples from zero.
- R6: With F = 0, a single asserted tick sample wakes the system.
- R7: On the wakeup edge, powerEn goes to 1 and sysRstN goes to 0. Let H = wrData & 0xFE0 as last written to offset 0x28. sysRstN stays 0 until the (H+1)-th tick counted from the wakeup edge, and goes to 1 on the cycle after that tick. With a tick every D cycles, this is (H+1)*D cycles low.
- R8: With H = 0, the reset pulse lasts exactly one tick period.
- R9: powerEn is 0 only while hibernating and sysRstN is 0 only while holding reset. The two outputs are never 0 at the same time.
- R10: The hibernate request clears itself on wakeup. A later write of 1 to 0x20 hibernates again without a 0 being written first.
- R11: The reset defaults are F = 1952 and H = 3264.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable at the reference tick rate (about 32 kHz) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register byte offset |
| wrData | input | 32 | Register write data |
| wakePinN | input | 1 | Asynchronous active-low wakeup pin |
| powerEn | output | 1 | Power enable, low only while hibernating |
| sysRstN | output | 1 | Active-low system reset, low only during the post-wakeup hold |

## Verification
The bench targets the off-by-one corners of the wakeup filter:
- A pulse of exactly F asserted samples must not wake the system. A design that compared against F-1, or that failed to restart the count after a gap, would wake on it.
- A single sample must wake the system when F = 0.

The reset width is measured in cycles for H = 64 and for H = 0 (written with junk in the ignored low bits). An extra or missing hold tick, or a failure to mask the field, shows up directly as a wrong cycle count.

The bench also checks the self-clearing hibernate request by hibernating twice in a row without writing 0. It checks writes that must be ignored, and it checks the default durations after reset. A model that steps every clock catches any cycle where power and reset are both low, or where either changes on a cycle with no tick.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HIB  = 2'd1,
    ST_HOLD = 2'd2
  } hibState_t;

  typedef struct packed {
    logic filtClr;
    logic filtInc;
    logic holdClr;
    logic holdInc;
  } hibStrobe_t;
endpackage

// File: rtl/hib_datapath.sv
module hib_datapath
  import hib_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MSB    = 15,
  parameter int FILT_LSB    = 5,
  parameter int HOLD_MSB    = 11,
  parameter int HOLD_LSB    = 5,
  parameter logic [ADDR_W-1:0] HIB_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] HOLD_OFS = 8'h28,
  parameter int FILT_DEF = 1952,
  parameter int HOLD_DEF = 3264
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wakePinN,
  input  hibStrobe_t        strobe,
  output logic              hibReq,
  output logic              pinAct,
  output logic              filtDone,
  output logic              holdDone
);
  localparam int FILT_W  = FILT_MSB + 1;
  localparam int HOLD_W  = HOLD_MSB + 1;
  localparam int FFLD_W  = FILT_MSB - FILT_LSB + 1;
  localparam int HFLD_W  = HOLD_MSB - HOLD_LSB + 1;
  localparam logic [FFLD_W-1:0] FFLD_RST = FFLD_W'(FILT_DEF >> FILT_LSB);
  localparam logic [HFLD_W-1:0] HFLD_RST = HFLD_W'(HOLD_DEF >> HOLD_LSB);

  logic [SYNC_STAGES-1:0] syncPipe;
  logic [FFLD_W-1:0]      filtField;
  logic [HFLD_W-1:0]      holdField;
  logic [FILT_W-1:0]      filtLim, filtCnt;
  logic [HOLD_W-1:0]      holdLim, holdCnt;

  // Pin synchronizer, idles at the deasserted level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], wakePinN};
  end
  assign pinAct = ~syncPipe[SYNC_STAGES-1];

  // Duration fields; only the significant bits are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtField <= FFLD_RST;
      holdField <= HFLD_RST;
    end else if (wrEn) begin
      if (wrAddr == FILT_OFS) filtField <= wrData[FILT_MSB:FILT_LSB];
      if (wrAddr == HOLD_OFS) holdField <= wrData[HOLD_MSB:HOLD_LSB];
    end
  end
  assign filtLim = {filtField, {FILT_LSB{1'b0}}};
  assign holdLim = {holdField, {HOLD_LSB{1'b0}}};

  assign hibReq = wrEn && (wrAddr == HIB_OFS) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               filtCnt <= '0;
    else if (strobe.filtClr) filtCnt <= '0;
    else if (strobe.filtInc) filtCnt <= filtCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (strobe.holdClr) holdCnt <= '0;
    else if (strobe.holdInc) holdCnt <= holdCnt + 1'b1;
  end

  assign filtDone = (filtCnt == filtLim);
  assign holdDone = (holdCnt == holdLim);
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       hibReq,
  input  logic       pinAct,
  input  logic       filtDone,
  input  logic       holdDone,
  output hibStrobe_t strobe,
  output logic       powerEn,
  output logic       sysRstN
);
  hibState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_RUN: begin
        strobe.filtClr = 1'b1;
        strobe.holdClr = 1'b1;
        if (hibReq) stateNxt = ST_HIB;
      end
      ST_HIB: begin
        strobe.holdClr = 1'b1;
        if (tickEn) begin
          if (!pinAct)       strobe.filtClr = 1'b1;
          else if (filtDone) stateNxt = ST_HOLD;
          else               strobe.filtInc = 1'b1;
        end
      end
      ST_HOLD: begin
        strobe.filtClr = 1'b1;
        if (tickEn) begin
          if (holdDone) stateNxt = ST_RUN;
          else          strobe.holdInc = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  assign powerEn = (state != ST_HIB);
  assign sysRstN = (state != ST_HOLD);
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
  import hib_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] HIB_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] HOLD_OFS = 8'h28,
  parameter int FILT_DEF = 1952,
  parameter int HOLD_DEF = 3264
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wakePinN,
  output logic              powerEn,
  output logic              sysRstN
);
  hibStrobe_t strobe;
  logic hibReq, pinAct, filtDone, holdDone;

  hib_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HIB_OFS(HIB_OFS), .FILT_OFS(FILT_OFS), .HOLD_OFS(HOLD_OFS),
    .FILT_DEF(FILT_DEF), .HOLD_DEF(HOLD_DEF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wakePinN(wakePinN), .strobe(strobe), .hibReq(hibReq), .pinAct(pinAct),
    .filtDone(filtDone), .holdDone(holdDone)
  );

  hib_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .hibReq(hibReq), .pinAct(pinAct),
    .filtDone(filtDone), .holdDone(holdDone), .strobe(strobe),
    .powerEn(powerEn), .sysRstN(sysRstN)
  );
endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] HIB_OFS = 8'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wakePinN,
  input logic              powerEn,
  input logic              sysRstN
);
  logic hibWr1, hibWr0;
  assign hibWr1 = wrEn && (wrAddr == HIB_OFS) && wrData[0];
  assign hibWr0 = wrEn && (wrAddr == HIB_OFS) && !wrData[0];

  assert_never_both_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerEn || sysRstN);

  assert_hib_after_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerEn) |-> $past(hibWr1));

  assert_zero_write_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (powerEn && sysRstN && hibWr0) |=> powerEn);

  assert_wake_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> ($past(tickEn) && !sysRstN));

  assert_wake_needs_pin_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> $past(!wakePinN, 3));

  assert_release_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> ($past(tickEn) && powerEn));
endmodule

bind hib_wake_seq hib_wake_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIB_OFS(HIB_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .wakePinN(wakePinN), .powerEn(powerEn), .sysRstN(sysRstN)
);

// File: tb/tb_hib_wake_seq.sv
module tb_hib_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;

  logic clk = 1'b0;
  logic rstN, tickEn, wrEn, wakePinN;
  logic [7:0]  wrAddr;
  logic [31:0] wrData;
  logic powerEn, sysRstN;
  int nChecks = 0, nFail = 0;
  string curReq = "R1";
  bit cmpOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hib_wake_seq dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wakePinN(wakePinN), .powerEn(powerEn), .sysRstN(sysRstN)
  );

  // Behavioural reference: mode 0 run, 1 hibernate, 2 reset hold
  int mMode, mFilt, mHold, mFc, mHc;
  bit mS1, mS2;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mFilt = 1952; mHold = 3264; mFc = 0; mHc = 0; mS1 = 1; mS2 = 1;
    end else begin
      bit act;
      act = !mS2;
      if (mMode == 0) begin
        if (wrEn && wrAddr == 8'h20 && wrData[0]) begin mMode = 1; mFc = 0; end
      end else if (mMode == 1) begin
        if (tickEn) begin
          if (!act) mFc = 0;
          else if (mFc == mFilt) begin mMode = 2; mHc = 0; end
          else mFc++;
        end
      end else begin
        if (tickEn) begin
          if (mHc == mHold) mMode = 0;
          else mHc++;
        end
      end
      if (wrEn && wrAddr == 8'h24) mFilt = int'(wrData & 32'h0000FFE0);
      if (wrEn && wrAddr == 8'h28) mHold = int'(wrData & 32'h00000FE0);
      mS2 = mS1;
      mS1 = wakePinN;
    end
  end

  task automatic checkBit(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R9 covers the joint rule)
  initial forever begin
    @(negedge clk);
    if (cmpOn) begin
      checkBit({curReq, " powerEn"}, powerEn, mMode != 1);
      checkBit({curReq, " sysRstN"}, sysRstN, mMode != 2);
      checkBit("R9 both low", powerEn | sysRstN, 1'b1);
    end
  end

  // Tick generator
  initial begin
    int div = 0;
    tickEn = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % TICK_DIV;
      tickEn = (div == 0);
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrAddr = '0; wrData = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitWake(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (powerEn) begin seen = 1; break; end
    end
  endtask

  task automatic countLow(output int cnt);
    cnt = 0;
    while (!sysRstN && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    idle(3);
    rstN = 1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    bit seen;
    int lowCnt;
    rstN = 0; wrEn = 0; wrAddr = '0; wrData = '0; wakePinN = 1;
    @(negedge clk);
    cmpOn = 1;
    doReset();
    curReq = "R1";
    checkBit("R1 reset powerEn", powerEn, 1'b1);
    checkBit("R1 reset sysRstN", sysRstN, 1'b1);

    // F = 32, H = 64 (low bits junk)
    regWrite(8'h24, 32'h0000_003F);
    regWrite(8'h28, 32'h0000_005F);

    curReq = "R3";
    regWrite(8'h20, 32'h0000_0000);
    idle(4);
    checkBit("R3 write 0 ignored", powerEn, 1'b1);
    regWrite(8'h30, 32'h0000_0001);
    idle(4);
    checkBit("R3 other offset ignored", powerEn, 1'b1);

    curReq = "R2";
    regWrite(8'h20, 32'h0000_0001);
    checkBit("R2 hibernate entered", powerEn, 1'b0);
    curReq = "R3";
    regWrite(8'h20, 32'h0000_0001);
    idle(4);
    checkBit("R3 write in hibernate ignored", powerEn, 1'b0);

    curReq = "R5";
    wakePinN = 0; idle(10 * TICK_DIV); wakePinN = 1;
    idle(8);
    checkBit("R5 short pulse rejected", powerEn, 1'b0);

    curReq = "R4";
    wakePinN = 0; idle(32 * TICK_DIV); wakePinN = 1;
    idle(8);
    checkBit("R4 F samples do not wake", powerEn, 1'b0);

    wakePinN = 0;
    waitWake(200, seen);
    checkBit("R4 F+1 samples wake", seen, 1'b1);
    wakePinN = 1;
    curReq = "R7";
    checkBit("R7 reset low at wake", sysRstN, 1'b0);
    countLow(lowCnt);
    checkInt("R7 reset width cycles", lowCnt, 65 * TICK_DIV);
    idle(4);

    // R10: hibernate again without clearing
    curReq = "R10";
    regWrite(8'h20, 32'h0000_0001);
    checkBit("R10 second hibernate", powerEn, 1'b0);

    // F = 0 and H = 0 written with junk low bits
    curReq = "R6";
    regWrite(8'h24, 32'h0000_001F);
    regWrite(8'h28, 32'hFFFF_F01F);
    wakePinN = 0; idle(TICK_DIV); wakePinN = 1;
    waitWake(20, seen);
    checkBit("R6 single sample wakes", seen, 1'b1);
    curReq = "R8";
    countLow(lowCnt);
    checkInt("R8 one tick pulse", lowCnt, TICK_DIV);
    idle(4);

    // R11: defaults after reset
    curReq = "R11";
    doReset();
    regWrite(8'h20, 32'h0000_0001);
    checkBit("R11 hibernate", powerEn, 1'b0);
    wakePinN = 0; idle(1900 * TICK_DIV);
    checkBit("R11 default filter not yet met", powerEn, 1'b0);
    waitWake(400, seen);
    checkBit("R11 default filter wake", seen, 1'b1);
    wakePinN = 1;
    countLow(lowCnt);
    checkInt("R11 default reset width", lowCnt, 3265 * TICK_DIV);
    idle(4);
    checkBit("R1 back to run", powerEn & sysRstN, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule